// File: doc/BRIEF.md
# Frequency-Ranked Truncated Unary Encoder

This block takes a short message of 8-bit characters, presented one per clock after a start pulse. It builds a table of the distinct characters, counts the occurrences of each, and ranks the entries by count from highest to lowest. Each rank then receives a prefix codeword. Rank k is k ones followed by a zero. The lowest rank drops the closing zero. Once the table is settled, a single-cycle done pulse marks the point where two totals become valid: the uncompressed size, at a fixed 3 bits per character, and the compressed size, which is the sum of count times codeword length.

After done, the ranked table is read through a rank-select port. The port returns the symbol, its count, its codeword left-aligned in a 14-bit field, and the codeword length. An emit request replays the stored message as a serial bit stream, one bit per clock, using the codes just derived. A new start pulse discards everything and begins a fresh message at any time.

Top module: `fr_unary_encoder`

## Requirements
- R1: After the last character of a message of length 1..15 is accepted, `done` rises for exactly one clock cycle. Outside that cycle it stays low.
- R2: `n_distinct` equals the number of different character values among the accepted characters.
- R3: Reading rank r through `rank_sel` gives the symbol with the r-th highest count (r = 0 is the most frequent). `q_count` gives its occurrence count.
- R4: Symbols with equal counts are ranked by first appearance: the one seen earlier in the message gets the lower rank number.
- R5: For rank r below `n_distinct`-1, the codeword is r ones then a zero, and its length is r+1. Codewords are left-aligned in `q_code`: bit 13 is the first code bit, and all bits past the code length read 0.
- R6: When `n_distinct` > 1, the last rank r = `n_distinct`-1 has r ones with no closing zero, and its length is r. With six distinct symbols the lengths are 1, 2, 3, 4, 5, 5.
- R7: When the message holds one distinct symbol, that symbol's codeword is a single 0 with length 1.
- R8: `raw_total` equals 3 times the message length.
- R9: `packed_total` equals the sum over all distinct symbols of count times codeword length.
- R10: An `emit_req` after done starts a stream in the next cycle. The stream carries every character's codeword in message order, first code bit first, one bit per cycle with `bit_valid` high. `bit_last` marks the final bit, and `bit_valid` is low in the cycle after it.
- R11: A start with `msg_len` = 0 raises done in the next cycle with both totals 0. A later `emit_req` produces no `bit_valid`.
- R12: A start pulse during loading discards the partial message. The results then reflect only the characters that follow the new start.
- R13: `q_valid` is high only after done and only for `rank_sel` below `n_distinct`. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new message, clearing all results |
| msg_len | input | 4 | Number of characters to accept, 0..15, sampled with start |
| sym_valid | input | 1 | Qualifies sym_in during loading |
| sym_in | input | 8 | Message character |
| done | output | 1 | One-cycle pulse when results are valid |
| raw_total | output | 8 | Uncompressed size in bits |
| packed_total | output | 8 | Compressed size in bits |
| n_distinct | output | 4 | Count of distinct characters |
| rank_sel | input | 4 | Rank to inspect |
| q_valid | output | 1 | Query result is meaningful |
| q_sym | output | 8 | Symbol at the selected rank |
| q_count | output | 4 | Occurrences of that symbol |
| q_code | output | 14 | Left-aligned codeword |
| q_code_len | output | 4 | Codeword length in bits |
| emit_req | input | 1 | Request replay of the encoded message |
| bit_out | output | 1 | Serial code bit |
| bit_valid | output | 1 | bit_out carries a code bit |
| bit_last | output | 1 | Final bit of the replay |

## Verification
The hardest situations to reach are the ones where ranking by count alone is ambiguous. Several symbols share a count but first appear in different orders, and the truncated last code has to line up with that tie order. Directed messages are built so that a later-appearing symbol ties with an earlier one. One message holds fifteen distinct characters, which pushes the last code to the full 14 ones. Finally, a start is issued in the middle of loading, so that counts left over from the abandoned message would show up in both the table and the replayed stream.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RANK,
    ST_SUM,
    ST_DONE,
    ST_EMIT
  } fr_state_e;

  // Code length for a given rank when n_sym distinct symbols exist.
  function automatic int code_len(int rank, int n_sym);
    if (n_sym <= 1) return 1;
    if (rank == n_sym - 1) return rank;
    return rank + 1;
  endfunction

endpackage

// File: rtl/fr_symbol_table.sv
module fr_symbol_table import fr_pkg::*; #(
  parameter int SYM_W   = 8,
  parameter int MAX_LEN = 15,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  logic                              load_en,
  input  logic [SYM_W-1:0]                  sym_in,
  output logic [MAX_LEN-1:0][SYM_W-1:0]     syms,
  output logic [MAX_LEN-1:0][LEN_W-1:0]     cnts,
  output logic [MAX_LEN-1:0][IDX_W-1:0]     pos_idx,
  output logic [LEN_W-1:0]                  n_distinct,
  output logic [LEN_W-1:0]                  n_loaded
);

  logic [MAX_LEN-1:0][SYM_W-1:0] sym_q, sym_d;
  logic [MAX_LEN-1:0][LEN_W-1:0] cnt_q, cnt_d;
  logic [MAX_LEN-1:0][IDX_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0]              nd_q, nd_d;
  logic [LEN_W-1:0]              wr_q, wr_d;
  logic [MAX_LEN-1:0]            hit;
  logic [IDX_W-1:0]              hit_idx;
  logic [IDX_W-1:0]              slot;
  logic                          any_hit;

  // Parallel match against the symbols already in the table.
  always_comb begin
    hit = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      hit[i] = (LEN_W'(i) < nd_q) && (sym_q[i] == sym_in);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = MAX_LEN - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit;
  assign slot    = any_hit ? hit_idx : IDX_W'(nd_q);

  always_comb begin
    sym_d = sym_q;
    cnt_d = cnt_q;
    pos_d = pos_q;
    nd_d  = nd_q;
    wr_d  = wr_q;
    if (clear) begin
      cnt_d = '0;
      nd_d  = '0;
      wr_d  = '0;
    end else if (load_en) begin
      if (!any_hit) begin
        sym_d[slot] = sym_in;
        nd_d        = nd_q + 1'b1;
      end
      cnt_d[slot] = cnt_q[slot] + 1'b1;
      pos_d[wr_q] = slot;
      wr_d        = wr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= '0;
      cnt_q <= '0;
      pos_q <= '0;
      nd_q  <= '0;
      wr_q  <= '0;
    end else if (clear || load_en) begin
      sym_q <= sym_d;
      cnt_q <= cnt_d;
      pos_q <= pos_d;
      nd_q  <= nd_d;
      wr_q  <= wr_d;
    end
  end

  assign syms       = sym_q;
  assign cnts       = cnt_q;
  assign pos_idx    = pos_q;
  assign n_distinct = nd_q;
  assign n_loaded   = wr_q;

  assert_load_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !clear) |=> (n_loaded == $past(n_loaded) + 1'b1));

  assert_distinct_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    n_distinct <= n_loaded);

endmodule

// File: rtl/fr_ranker.sv
module fr_ranker import fr_pkg::*; #(
  parameter int MAX_LEN = 15,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rank_en,
  input  logic [MAX_LEN-1:0][LEN_W-1:0] cnts,
  input  logic [LEN_W-1:0]              n_distinct,
  output logic [MAX_LEN-1:0][IDX_W-1:0] rank_of,
  output logic [MAX_LEN-1:0][IDX_W-1:0] order
);

  logic [MAX_LEN-1:0][IDX_W-1:0] rank_d, rank_q;
  logic [MAX_LEN-1:0][IDX_W-1:0] order_d, order_q;

  // Rank = entries that beat this one: higher count, or equal count and
  // earlier table slot (table slots follow first appearance).
  always_comb begin
    for (int i = 0; i < MAX_LEN; i++) begin
      rank_d[i] = '0;
      for (int j = 0; j < MAX_LEN; j++) begin
        if ((LEN_W'(j) < n_distinct) && (j != i)) begin
          if ((cnts[j] > cnts[i]) || ((cnts[j] == cnts[i]) && (j < i))) begin
            rank_d[i] = rank_d[i] + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    order_d = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (LEN_W'(i) < n_distinct) order_d[rank_d[i]] = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q  <= '0;
      order_q <= '0;
    end else if (rank_en) begin
      rank_q  <= rank_d;
      order_q <= order_d;
    end
  end

  assign rank_of = rank_q;
  assign order   = order_q;

  for (genvar k = 0; k < MAX_LEN - 1; k++) begin : g_rank_chk
    assert_rank_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rank_en) && (LEN_W'(k + 1) < n_distinct))
        |-> (cnts[order_q[k]] >= cnts[order_q[k + 1]]));

    assert_tie_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rank_en) && (LEN_W'(k + 1) < n_distinct)
        && (cnts[order_q[k]] == cnts[order_q[k + 1]]))
        |-> (order_q[k] < order_q[k + 1]));
  end

endmodule

// File: rtl/fr_bit_emitter.sv
module fr_bit_emitter import fr_pkg::*; #(
  parameter int MAX_LEN = 15,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          go,
  input  logic [MAX_LEN-1:0][IDX_W-1:0] pos_idx,
  input  logic [MAX_LEN-1:0][IDX_W-1:0] rank_of,
  input  logic [LEN_W-1:0]              n_distinct,
  input  logic [LEN_W-1:0]              n_chars,
  output logic                          bit_out,
  output logic                          bit_valid,
  output logic                          bit_last
);

  logic             active_q, active_d;
  logic [IDX_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] bitn_q, bitn_d;
  logic [IDX_W-1:0] cur_rank;
  logic [LEN_W-1:0] cur_len;
  logic             end_of_code;
  logic             end_of_msg;

  assign cur_rank    = rank_of[pos_idx[pos_q]];
  assign cur_len     = LEN_W'(code_len(int'(cur_rank), int'(n_distinct)));
  assign end_of_code = (bitn_q == cur_len - 1'b1);
  assign end_of_msg  = (LEN_W'(pos_q) == n_chars - 1'b1);

  always_comb begin
    active_d = active_q;
    pos_d    = pos_q;
    bitn_d   = bitn_q;
    if (clear) begin
      active_d = 1'b0;
      pos_d    = '0;
      bitn_d   = '0;
    end else if (go && !active_q) begin
      active_d = 1'b1;
      pos_d    = '0;
      bitn_d   = '0;
    end else if (active_q) begin
      if (end_of_code) begin
        bitn_d = '0;
        if (end_of_msg) active_d = 1'b0;
        else            pos_d    = pos_q + 1'b1;
      end else begin
        bitn_d = bitn_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      bitn_q   <= '0;
    end else if (clear || go || active_q) begin
      active_q <= active_d;
      pos_q    <= pos_d;
      bitn_q   <= bitn_d;
    end
  end

  // Bit b of a rank-r code is 1 while b < r.
  assign bit_out   = active_q && (bitn_q < LEN_W'(cur_rank));
  assign bit_valid = active_q;
  assign bit_last  = active_q && end_of_code && end_of_msg;

  assert_stream_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_last |=> !bit_valid);

endmodule

// File: rtl/fr_unary_encoder.sv
module fr_unary_encoder import fr_pkg::*; #(
  parameter int SYM_W    = 8,
  parameter int MAX_LEN  = 15,
  parameter int CW_W     = 14,
  parameter int RAW_BITS = 3,
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int TOT_W   = $clog2(MAX_LEN * ((CW_W > RAW_BITS) ? CW_W : RAW_BITS) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_in,
  output logic             done,
  output logic [TOT_W-1:0] raw_total,
  output logic [TOT_W-1:0] packed_total,
  output logic [LEN_W-1:0] n_distinct,
  input  logic [IDX_W-1:0] rank_sel,
  output logic             q_valid,
  output logic [SYM_W-1:0] q_sym,
  output logic [LEN_W-1:0] q_count,
  output logic [CW_W-1:0]  q_code,
  output logic [LEN_W-1:0] q_code_len,
  input  logic             emit_req,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             bit_last
);

  fr_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             done_q, done_d;
  logic [TOT_W-1:0] raw_q, raw_d, pk_q, pk_d;
  logic [TOT_W-1:0] raw_calc, pk_calc;
  logic             load_en, rank_en, go;

  logic [MAX_LEN-1:0][SYM_W-1:0] syms;
  logic [MAX_LEN-1:0][LEN_W-1:0] cnts;
  logic [MAX_LEN-1:0][IDX_W-1:0] pos_idx;
  logic [MAX_LEN-1:0][IDX_W-1:0] rank_of;
  logic [MAX_LEN-1:0][IDX_W-1:0] order;
  logic [LEN_W-1:0]              nd;
  logic [LEN_W-1:0]              n_loaded;
  logic [IDX_W-1:0]              q_idx;
  logic                          res_ready;

  assign load_en = (state_q == ST_LOAD) && sym_valid && !start;
  assign rank_en = (state_q == ST_RANK) && !start;
  assign go      = (state_q == ST_DONE) && emit_req && (len_q != '0) && !start;

  fr_symbol_table #(.SYM_W(SYM_W), .MAX_LEN(MAX_LEN)) i_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .load_en    (load_en),
    .sym_in     (sym_in),
    .syms       (syms),
    .cnts       (cnts),
    .pos_idx    (pos_idx),
    .n_distinct (nd),
    .n_loaded   (n_loaded)
  );

  fr_ranker #(.MAX_LEN(MAX_LEN)) i_ranker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rank_en    (rank_en),
    .cnts       (cnts),
    .n_distinct (nd),
    .rank_of    (rank_of),
    .order      (order)
  );

  fr_bit_emitter #(.MAX_LEN(MAX_LEN)) i_emitter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .go         (go),
    .pos_idx    (pos_idx),
    .rank_of    (rank_of),
    .n_distinct (nd),
    .n_chars    (len_q),
    .bit_out    (bit_out),
    .bit_valid  (bit_valid),
    .bit_last   (bit_last)
  );

  // Totals from the settled ranks.
  assign raw_calc = TOT_W'(len_q) * TOT_W'(RAW_BITS);

  always_comb begin
    pk_calc = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (LEN_W'(i) < nd) begin
        pk_calc = pk_calc + TOT_W'(cnts[i]) * TOT_W'(code_len(int'(rank_of[i]), int'(nd)));
      end
    end
  end

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    done_d  = 1'b0;
    raw_d   = raw_q;
    pk_d    = pk_q;
    if (start) begin
      len_d = msg_len;
      raw_d = '0;
      pk_d  = '0;
      if (msg_len == '0) begin
        state_d = ST_DONE;
        done_d  = 1'b1;
      end else begin
        state_d = ST_LOAD;
      end
    end else begin
      unique case (state_q)
        ST_LOAD: if (load_en && (n_loaded == len_q - 1'b1)) state_d = ST_RANK;
        ST_RANK: state_d = ST_SUM;
        ST_SUM: begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          raw_d   = raw_calc;
          pk_d    = pk_calc;
        end
        ST_DONE: if (go) state_d = ST_EMIT;
        ST_EMIT: if (bit_last) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      done_q  <= 1'b0;
      raw_q   <= '0;
      pk_q    <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      done_q  <= done_d;
      raw_q   <= raw_d;
      pk_q    <= pk_d;
    end
  end

  assign done         = done_q;
  assign raw_total    = raw_q;
  assign packed_total = pk_q;
  assign n_distinct   = nd;

  // Rank-indexed query port.
  assign res_ready  = (state_q == ST_DONE) || (state_q == ST_EMIT);
  assign q_idx      = order[rank_sel];
  assign q_valid    = res_ready && (LEN_W'(rank_sel) < nd);
  assign q_sym      = q_valid ? syms[q_idx] : '0;
  assign q_count    = q_valid ? cnts[q_idx] : '0;
  assign q_code_len = q_valid ? LEN_W'(code_len(int'(rank_sel), int'(nd))) : '0;

  always_comb begin
    q_code = '0;
    for (int b = 0; b < CW_W; b++) begin
      q_code[CW_W - 1 - b] = q_valid && (b < int'(rank_sel));
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_empty_msg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (msg_len == '0)) |=> (done && (packed_total == '0) && (raw_total == '0)));

  assert_emit_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (state_q == ST_EMIT));

endmodule

// File: tb/test_fr_unary_encoder.sv
module test_fr_unary_encoder;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] msg_len;
  logic       sym_valid;
  logic [7:0] sym_in;
  logic       done;
  logic [7:0] raw_total;
  logic [7:0] packed_total;
  logic [3:0] n_distinct;
  logic [3:0] rank_sel;
  logic       q_valid;
  logic [7:0] q_sym;
  logic [3:0] q_count;
  logic [13:0] q_code;
  logic [3:0] q_code_len;
  logic       emit_req;
  logic       bit_out;
  logic       bit_valid;
  logic       bit_last;

  int total = 0;
  int bad   = 0;

  logic [7:0] msg [15];
  int         mlen;
  logic [7:0] esym [15];
  int         ecnt [15];
  int         elen [15];
  int         en;
  int         epacked;

  fr_unary_encoder i_fr_unary_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
    .sym_valid(sym_valid), .sym_in(sym_in), .done(done),
    .raw_total(raw_total), .packed_total(packed_total), .n_distinct(n_distinct),
    .rank_sel(rank_sel), .q_valid(q_valid), .q_sym(q_sym), .q_count(q_count),
    .q_code(q_code), .q_code_len(q_code_len), .emit_req(emit_req),
    .bit_out(bit_out), .bit_valid(bit_valid), .bit_last(bit_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_msg(string s);
    mlen = s.len();
    for (int i = 0; i < 15; i++) msg[i] = (i < mlen) ? s[i] : 8'h00;
  endtask

  // Expected table from the requirements: first-appearance order, stable
  // descending sort by count, truncated unary lengths.
  task automatic model();
    int found;
    en = 0;
    for (int p = 0; p < mlen; p++) begin
      found = -1;
      for (int k = 0; k < en; k++) if (esym[k] == msg[p]) found = k;
      if (found < 0) begin
        esym[en] = msg[p];
        ecnt[en] = 1;
        en++;
      end else begin
        ecnt[found]++;
      end
    end
    for (int a = 1; a < en; a++) begin
      logic [7:0] ks;
      int kc;
      int b;
      ks = esym[a];
      kc = ecnt[a];
      b  = a - 1;
      while (b >= 0 && ecnt[b] < kc) begin
        esym[b + 1] = esym[b];
        ecnt[b + 1] = ecnt[b];
        b--;
      end
      esym[b + 1] = ks;
      ecnt[b + 1] = kc;
    end
    epacked = 0;
    for (int r = 0; r < en; r++) begin
      elen[r] = (en == 1) ? 1 : ((r == en - 1) ? r : r + 1);
      epacked += ecnt[r] * elen[r];
    end
  endtask

  function automatic int exp_code(int r);
    int c;
    c = 0;
    for (int b = 0; b < r; b++) c |= (1 << (13 - b));
    return c;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; msg_len = '0; sym_valid = 1'b0;
    sym_in = '0; rank_sel = '0; emit_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_msg();
    @(negedge clk);
    start = 1'b1;
    msg_len = 4'(mlen);
    @(negedge clk);
    start = 1'b0;
    for (int p = 0; p < mlen; p++) begin
      sym_valid = 1'b1;
      sym_in = msg[p];
      @(negedge clk);
    end
    sym_valid = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int seen;
    seen = 0;
    for (int c = 0; c < 40 && seen == 0; c++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    check("R1", {tag, " done seen"}, seen, 1);
    @(negedge clk);
    check("R1", {tag, " done single cycle"}, int'(done), 0);
  endtask

  task automatic check_table(string tag);
    model();
    check("R2", {tag, " distinct"}, int'(n_distinct), en);
    check("R8", {tag, " raw total"}, int'(raw_total), 3 * mlen);
    check("R9", {tag, " packed total"}, int'(packed_total), epacked);
    for (int r = 0; r < en; r++) begin
      rank_sel = 4'(r);
      #1;
      check("R13", {tag, " q_valid in range"}, int'(q_valid), 1);
      check("R4", {tag, " symbol at rank"}, int'(q_sym), int'(esym[r]));
      check("R3", {tag, " count at rank"}, int'(q_count), ecnt[r]);
      check("R5", {tag, " codeword"}, int'(q_code), exp_code(r));
      check("R6", {tag, " code length"}, int'(q_code_len), elen[r]);
    end
    if (en < 15) begin
      rank_sel = 4'(en);
      #1;
      check("R13", {tag, " q_valid out of range"}, int'(q_valid), 0);
    end
  endtask

  task automatic check_stream(string tag);
    logic eb [256];
    int n;
    int got;
    int errs;
    int lastpos;
    int lastseen;
    n = 0;
    for (int p = 0; p < mlen; p++) begin
      int r;
      r = 0;
      for (int k = 0; k < en; k++) if (esym[k] == msg[p]) r = k;
      for (int b = 0; b < elen[r]; b++) begin
        eb[n] = (b < r);
        n++;
      end
    end
    @(negedge clk);
    emit_req = 1'b1;
    @(negedge clk);
    emit_req = 1'b0;
    got = 0; errs = 0; lastpos = -1; lastseen = 0;
    for (int c = 0; c < 300 && lastseen == 0; c++) begin
      if (bit_valid) begin
        if (got < n && bit_out !== eb[got]) errs++;
        if (bit_last) begin
          lastseen = 1;
          lastpos = got;
        end
        got++;
      end
      if (lastseen == 0) @(negedge clk);
    end
    check("R10", {tag, " stream bit count"}, got, n);
    check("R10", {tag, " stream bit errors"}, errs, 0);
    check("R10", {tag, " last flag position"}, lastpos, n - 1);
    @(negedge clk);
    check("R10", {tag, " valid low after last"}, int'(bit_valid), 0);
  endtask

  task automatic t_reset();
    check("R1", "reset done", int'(done), 0);
    check("R10", "reset bit_valid", int'(bit_valid), 0);
    check("R13", "reset q_valid", int'(q_valid), 0);
    check("R9", "reset packed", int'(packed_total), 0);
  endtask

  task automatic t_six_symbols();
    set_msg("BACABDACAFBCDEA");
    load_msg();
    wait_done("six");
    check_table("six");
    rank_sel = 4'd5;
    #1;
    check("R6", "six last rank length", int'(q_code_len), 5);
    check_stream("six");
  endtask

  task automatic t_ties();
    set_msg("XYXYZ");
    load_msg();
    wait_done("tie");
    check_table("tie");
    rank_sel = 4'd0;
    #1;
    check("R4", "tie earlier symbol first", int'(q_sym), int'("X"));
    check_stream("tie");
  endtask

  task automatic t_single();
    set_msg("QQQQ");
    load_msg();
    wait_done("single");
    rank_sel = 4'd0;
    #1;
    check("R7", "single code", int'(q_code), 0);
    check("R7", "single length", int'(q_code_len), 1);
    check_table("single");
    check_stream("single");
  endtask

  task automatic t_all_distinct();
    string s;
    s = "abcdefghijklmno";
    set_msg(s);
    load_msg();
    wait_done("distinct15");
    check_table("distinct15");
    rank_sel = 4'd14;
    #1;
    check("R6", "distinct15 last code all ones", int'(q_code), 16383);
    check("R6", "distinct15 last length", int'(q_code_len), 14);
    check_stream("distinct15");
  endtask

  task automatic t_zero_len();
    int any;
    @(negedge clk);
    start = 1'b1;
    msg_len = 4'd0;
    @(negedge clk);
    start = 1'b0;
    check("R11", "zero length done", int'(done), 1);
    check("R11", "zero length packed", int'(packed_total), 0);
    check("R11", "zero length raw", int'(raw_total), 0);
    emit_req = 1'b1;
    @(negedge clk);
    emit_req = 1'b0;
    any = 0;
    for (int c = 0; c < 5; c++) begin
      if (bit_valid) any = 1;
      @(negedge clk);
    end
    check("R11", "zero length no stream", any, 0);
  endtask

  task automatic t_restart();
    @(negedge clk);
    start = 1'b1;
    msg_len = 4'd9;
    @(negedge clk);
    start = 1'b0;
    for (int p = 0; p < 4; p++) begin
      sym_valid = 1'b1;
      sym_in = 8'h5A;
      @(negedge clk);
    end
    sym_valid = 1'b0;
    set_msg("MNNPM");
    load_msg();
    wait_done("R12 restart");
    check_table("restart R12");
    check_stream("restart R12");
  endtask

  initial begin
    do_reset();
    t_reset();
    t_six_symbols();
    t_ties();
    t_single();
    t_all_distinct();
    t_zero_len();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule